// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block sequences the start-up of a switching regulator in the digital domain. When enable goes high, it latches the requested reference code and waits a fixed number of switching ticks. It then ramps the reference code linearly up to the latched target, one step per switching tick, over a set number of ticks. Alongside the ramp it produces a start offset code for the remote-sense path. The offset starts at a fixed value and falls linearly to zero over the first part of the ramp.

The block also decides when the power-stage drivers may switch. It compares the ramping reference with a sampled code of the output feedback. While the feedback is at or above the reference, the drivers stay off, so a regulator that starts into an already charged output does not pull that output down. Once the reference passes the feedback, or at the latest when the ramp ends, the drivers are released and stay on. A done flag reports that the ramp has completed and the reference sits at the target. Dropping enable clears everything at the next clock edge.

The reference step uses a remainder accumulator, so no divider is needed. The reference after j ramp ticks is the target times j divided by the ramp length, rounded down. The same scheme produces the offset decay. The ramp length must be larger than the largest reference code. The offset start value must be smaller than the offset decay length, and the decay length must not exceed the ramp length.

Top module: `ss_ramp_seq`

## Requirements
- R1: After enable is sampled high from idle, the reference output is 0 and the offset output equals OFS_CODE for the first DELAY_CYC switching ticks.
- R2: After the delay, the reference after j ramp ticks equals floor(T*j/RAMP_CYC), where T is the latched target. It is never decreasing, reaches T exactly on tick RAMP_CYC and holds there.
- R3: The offset after j ramp ticks equals OFS_CODE - floor(OFS_CODE*min(j,OFS_CYC)/OFS_CYC). It is zero from ramp tick OFS_CYC onward and whenever the done flag is high.
- R4: While enable is high, the reference output changes only on a clock edge at which tick_i is high.
- R5: The driver enable stays low through the delay and while the feedback code is greater than or equal to the reference. It goes high by the second clock edge after the reference first exceeds the feedback, and it then stays high while enable is high.
- R6: If the reference never exceeds the feedback, the driver enable goes high one clock after the ramp completes.
- R7: The done flag is high only after RAMP_CYC ramp ticks have passed and the reference equals the target. It stays high until enable drops.
- R8: When enable is sampled low, the reference, the offset, the driver enable and the done flag are all zero after that clock edge, and ticks have no effect. Enabling again restarts the sequence from R1.
- R9: The target code is latched on the clock edge that leaves idle. Changes of target_i after that edge do not affect the ramp.
- R10: An asynchronous low on rst_ni forces the reference, offset, driver enable and done flag to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable; low resets the sequence |
| tick_i | input | 1 | One-clock pulse per switching cycle |
| target_i | input | REF_W | Final reference code, latched at start |
| fb_i | input | REF_W | Sampled output feedback code |
| ref_o | output | REF_W | Ramping reference code |
| ofs_o | output | OFS_W | Remote-sense start offset code |
| drv_en_o | output | 1 | Power-stage driver enable |
| done_o | output | 1 | Soft-start complete flag |

## Verification
The bench builds the block with REF_W=4, DELAY_CYC=4, OFS_CYC=10, RAMP_CYC=20 and OFS_CODE=7. With these values a whole start-up takes a few dozen ticks. This lets every tick of several complete ramps be compared against the floor formulas. Short parameters also bring the corner cases within reach: a feedback above the final target, a zero target, a feedback crossed only on the last tick, a target changed during the ramp, and the offset running out partway through the ramp.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_RAMP  = 2'd2,
    PH_DONE  = 2'd3
  } ss_phase_e;
endpackage

// File: rtl/ss_phase_ctrl.sv
module ss_phase_ctrl
  import ss_pkg::*;
#(
  parameter int DELAY_CYC = 64,
  parameter int OFS_CYC   = 640,
  parameter int RAMP_CYC  = 1280
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      tick_i,
  output ss_phase_e phase_o,
  output logic      start_o,
  output logic      step_ref_o,
  output logic      step_ofs_o
);
  localparam int CNT_MAX = (RAMP_CYC > DELAY_CYC) ? RAMP_CYC : DELAY_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] RMP_LAST = CNT_W'(RAMP_CYC - 1);
  localparam logic [CNT_W-1:0] OFS_LIM  = CNT_W'(OFS_CYC);

  ss_phase_e        phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_q <= PH_DELAY;
          cnt_q   <= '0;
        end
        PH_DELAY: if (tick_i) begin
          if (cnt_q == DLY_LAST) begin
            phase_q <= PH_RAMP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_RAMP: if (tick_i) begin
          if (cnt_q == RMP_LAST) begin
            phase_q <= PH_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign start_o    = en_i && (phase_q == PH_IDLE);
  assign step_ref_o = en_i && tick_i && (phase_q == PH_RAMP);
  // cnt_q holds ramp ticks already taken
  assign step_ofs_o = step_ref_o && (cnt_q < OFS_LIM);
endmodule

// File: rtl/ss_frac_ramp.sv
// val_o = floor(amt_i * steps / LEN), requires amt_i < LEN
module ss_frac_ramp #(
  parameter int VAL_W = 10,
  parameter int LEN   = 1280
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [VAL_W-1:0] amt_i,
  output logic [VAL_W-1:0] val_o
);
  localparam int ACC_W = $clog2(2 * LEN);
  localparam logic [ACC_W-1:0] LEN_C = ACC_W'(LEN);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [VAL_W-1:0] val_q;

  assign sum = acc_q + ACC_W'(amt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      val_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      val_q <= '0;
    end else if (step_i) begin
      if (sum >= LEN_C) begin
        acc_q <= sum - LEN_C;
        val_q <= val_q + VAL_W'(1);
      end else begin
        acc_q <= sum;
      end
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/ss_drv_gate.sv
module ss_drv_gate
  import ss_pkg::*;
#(
  parameter int REF_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  ss_phase_e        phase_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [REF_W-1:0] fb_i,
  output logic             drv_en_o
);
  logic drv_q;
  logic release_c;

  // precharged output: hold off until reference passes feedback or ramp ends
  assign release_c = (phase_i == PH_DONE) ||
                     ((phase_i == PH_RAMP) && (ref_i > fb_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        drv_q <= 1'b0;
    else if (!en_i)     drv_q <= 1'b0;
    else if (release_c) drv_q <= 1'b1;
  end

  assign drv_en_o = drv_q;
endmodule

// File: rtl/ss_ramp_seq.sv
module ss_ramp_seq
  import ss_pkg::*;
#(
  parameter int REF_W     = 10,
  parameter int DELAY_CYC = 64,
  parameter int OFS_CYC   = 640,
  parameter int RAMP_CYC  = 1280,
  parameter int OFS_CODE  = 85,
  localparam int OFS_W    = $clog2(OFS_CODE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [REF_W-1:0] target_i,
  input  logic [REF_W-1:0] fb_i,
  output logic [REF_W-1:0] ref_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic             drv_en_o,
  output logic             done_o
);
  localparam logic [OFS_W-1:0] OFS_INIT = OFS_W'(OFS_CODE);

  ss_phase_e        phase;
  logic             start, step_ref, step_ofs, clr;
  logic [REF_W-1:0] tgt_q;
  logic [REF_W-1:0] ref_val;
  logic [OFS_W-1:0] ofs_dec;

  ss_phase_ctrl #(
    .DELAY_CYC(DELAY_CYC),
    .OFS_CYC  (OFS_CYC),
    .RAMP_CYC (RAMP_CYC)
  ) i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick_i),
    .phase_o   (phase),
    .start_o   (start),
    .step_ref_o(step_ref),
    .step_ofs_o(step_ofs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tgt_q <= '0;
    else if (start) tgt_q <= target_i;
  end

  assign clr = start || !en_i;

  ss_frac_ramp #(
    .VAL_W(REF_W),
    .LEN  (RAMP_CYC)
  ) i_ref_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .step_i(step_ref),
    .amt_i (tgt_q),
    .val_o (ref_val)
  );

  ss_frac_ramp #(
    .VAL_W(OFS_W),
    .LEN  (OFS_CYC)
  ) i_ofs_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .step_i(step_ofs),
    .amt_i (OFS_INIT),
    .val_o (ofs_dec)
  );

  ss_drv_gate #(
    .REF_W(REF_W)
  ) i_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .phase_i (phase),
    .ref_i   (ref_val),
    .fb_i    (fb_i),
    .drv_en_o(drv_en_o)
  );

  assign ref_o  = ref_val;
  assign ofs_o  = (phase == PH_IDLE) ? '0 : (OFS_INIT - ofs_dec);
  assign done_o = (phase == PH_DONE) && (ref_val == tgt_q);
endmodule

// File: rtl/ss_ramp_seq_chk.sv
module ss_ramp_seq_chk #(
  parameter int REF_W    = 10,
  parameter int OFS_CODE = 85,
  parameter int OFS_W    = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             tick_i,
  input logic [REF_W-1:0] ref_o,
  input logic [OFS_W-1:0] ofs_o,
  input logic             drv_en_o,
  input logic             done_o
);
  assert_start_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |=> (ref_o == '0) && (ofs_o == OFS_W'(OFS_CODE)));

  assert_ref_monotonic_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (ref_o >= $past(ref_o)));

  assert_ofs_zero_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ofs_o == '0));

  assert_ref_tick_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(ref_o));

  assert_drv_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o && en_i) |=> drv_en_o);

  assert_drv_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && en_i) |=> drv_en_o);

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && en_i) |=> done_o);

  assert_disable_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ref_o == '0) && (ofs_o == '0) && !drv_en_o && !done_o);
endmodule

bind ss_ramp_seq ss_ramp_seq_chk #(
  .REF_W   (REF_W),
  .OFS_CODE(OFS_CODE),
  .OFS_W   (OFS_W)
) i_ss_ramp_seq_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .tick_i  (tick_i),
  .ref_o   (ref_o),
  .ofs_o   (ofs_o),
  .drv_en_o(drv_en_o),
  .done_o  (done_o)
);

// File: tb/test_ss_ramp_seq.sv
module test_ss_ramp_seq;
  localparam int REF_W = 4;
  localparam int DLY   = 4;
  localparam int OFSC  = 10;
  localparam int RMP   = 20;
  localparam int OFSV  = 7;
  localparam int OFS_W = $clog2(OFSV + 1);
  localparam int NTICK = DLY + RMP + 2;

  typedef struct packed {
    logic [3:0] tgt;
    logic [3:0] fb;
    logic [3:0] tgt_late; // driven after the third tick
    logic [5:0] drv_n;    // tick count at which drivers are expected on
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{tgt: 4'd15, fb: 4'd0,  tgt_late: 4'd15, drv_n: 6'd6},
    '{tgt: 4'd10, fb: 4'd6,  tgt_late: 4'd10, drv_n: 6'd18},
    '{tgt: 4'd12, fb: 4'd15, tgt_late: 4'd12, drv_n: 6'd24},
    '{tgt: 4'd0,  fb: 4'd0,  tgt_late: 4'd0,  drv_n: 6'd24},
    '{tgt: 4'd9,  fb: 4'd3,  tgt_late: 4'd2,  drv_n: 6'd13},
    '{tgt: 4'd15, fb: 4'd14, tgt_late: 4'd15, drv_n: 6'd24}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             tick = 1'b0;
  logic [REF_W-1:0] target = '0;
  logic [REF_W-1:0] fb = '0;
  logic [REF_W-1:0] ref_code;
  logic [OFS_W-1:0] ofs;
  logic             drv_en;
  logic             done;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  ss_ramp_seq #(
    .REF_W(REF_W), .DELAY_CYC(DLY), .OFS_CYC(OFSC), .RAMP_CYC(RMP), .OFS_CODE(OFSV)
  ) i_ss_ramp_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .target_i(target), .fb_i(fb),
    .ref_o(ref_code), .ofs_o(ofs), .drv_en_o(drv_en), .done_o(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ref(input int t, input int n);
    int j;
    if (n <= DLY) return 0;
    j = n - DLY;
    if (j > RMP) j = RMP;
    return (t * j) / RMP;
  endfunction

  function automatic int exp_ofs(input int n);
    int j;
    if (n <= DLY) return OFSV;
    j = n - DLY;
    if (j > OFSC) j = OFSC;
    return OFSV - (OFSV * j) / OFSC;
  endfunction

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic start(input logic [3:0] t, input logic [3:0] f);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    target = t;
    fb = f;
    en = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_zero(input string req);
    check(req, "ref", int'(ref_code), 0);
    check(req, "ofs", int'(ofs), 0);
    check(req, "drv", int'(drv_en), 0);
    check(req, "done", int'(done), 0);
  endtask

  initial begin
    #4_000_000;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    // R10 reset state
    #5;
    check_zero("R10");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_zero("R10");

    foreach (VECS[v]) begin
      start(VECS[v].tgt, VECS[v].fb);
      // R1 state right after enable
      check("R1", "ref", int'(ref_code), 0);
      check("R1", "ofs", int'(ofs), OFSV);
      check("R5", "drv", int'(drv_en), 0);
      check("R7", "done", int'(done), 0);
      for (int n = 1; n <= NTICK; n++) begin
        do_tick();
        if (n == 3) target = VECS[v].tgt_late; // R9 late change ignored
        check(n <= DLY ? "R1" : "R2", "ref", int'(ref_code), exp_ref(int'(VECS[v].tgt), n));
        check("R3", "ofs", int'(ofs), exp_ofs(n));
        check(n >= DLY + RMP ? "R6" : "R5", "drv", int'(drv_en), (n >= int'(VECS[v].drv_n)) ? 1 : 0);
        check("R7", "done", int'(done), (n >= DLY + RMP) ? 1 : 0);
      end
    end

    // R4: no ticks, reference holds
    start(4'd15, 4'd0);
    for (int n = 1; n <= DLY + 8; n++) do_tick();
    begin
      int held;
      held = int'(ref_code);
      repeat (9) @(negedge clk);
      check("R4", "ref held", int'(ref_code), held);
      check("R4", "ref value", held, exp_ref(15, DLY + 8));
    end

    // R8: disable mid-ramp clears at once, ticks ignored while low
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check_zero("R8");
    do_tick();
    do_tick();
    check_zero("R8");

    // R8: re-enable restarts from delay
    start(4'd10, 4'd0);
    check("R8", "restart ofs", int'(ofs), OFSV);
    for (int n = 1; n <= DLY + 4; n++) do_tick();
    check("R8", "restart ref", int'(ref_code), exp_ref(10, DLY + 4));

    // R10: asynchronous reset mid-ramp
    #3;
    rst_n = 1'b0;
    #1;
    check_zero("R10");
    @(negedge clk) rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule